// File: doc/BRIEF.md
# PS/2 Device-Side Link Transceiver

This block is the peripheral end of a two-wire PS/2 link. The device is the clock master in both directions. It serialises bytes from its user toward the host and deserialises bytes the host sends. Each received frame closes with the line-control acknowledge bit. Both wires are open-drain: for each line the block outputs a drive-low enable and takes in the sensed line level. A released line is pulled high outside the block.

On the user side, a byte to send is offered with a valid/ready handshake. Each received byte is delivered as a one-cycle pulse, together with a parity-error flag and a framing-error flag. If the host holds the clock low while the device has it released, the block drops the frame and pulses an abort output. The clock half-period and the minimum clock-high time required before sending are parameters, given in system clock cycles. Command handling and key scanning belong to other blocks.

Top module: `ps2_dev_xcvr`

## Requirements
- R1: A transmitted frame is 11 bits, each valid on the falling clock edge: start bit 0, then the 8 data bits least significant first, then an odd parity bit (the data plus parity hold an odd count of ones), then stop bit 1.
- R2: Every clock pulse the device produces is held low for exactly HALF_CYC cycles, and the released gap between two pulses of a frame is also HALF_CYC cycles.
- R3: `tx_ready` is high only while the block is idle, both lines read high, and the clock has read high continuously for at least HOLD_CYC cycles. While the host holds the clock low, no byte is accepted and no clock is produced.
- R4: While sending, if the clock still reads low at the end of a released half-period, the block pulses `abort` for one cycle, releases both lines, and produces no further clock pulses. The byte is dropped.
- R5: At idle, clock high with data low is a host request to send. The device then clocks in 8 data bits (least significant first) and a parity bit, sampling each at the end of a released half. It delivers the byte with a one-cycle `rx_valid`.
- R6: A received parity bit that leaves an even count of ones sets `rx_parity_err` together with the byte, and the byte is still delivered.
- R7: If the stop bit reads low, the device keeps clocking until data reads high, sets `rx_frame_err` with the byte, and then acknowledges.
- R8: After a good stop bit, the device drives data low across exactly one clock pulse (the acknowledge). `rx_valid` is asserted while that data drive is still on, and both drives are off in the next cycle.
- R9: While receiving, if the clock reads low at the end of a released half, the block pulses `abort`, releases both lines, and delivers no byte.
- R10: A host request to send that is detected at idle wins over a pending transmit. The pending byte is sent afterwards, once the hold time is met again.
- R11: After reset both drives are off, `rx_valid` and `abort` are low, and `tx_ready` stays low until the clock has read high for the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block will take the offered byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data and flags are new |
| rx_parity_err | output | 1 | Received parity was wrong |
| rx_frame_err | output | 1 | Received stop bit was low |
| abort | output | 1 | One-cycle pulse: frame dropped because host held clock low |
| ps2_clk_in | input | 1 | Sensed clock line level |
| ps2_clk_drv | output | 1 | 1 pulls the clock line low |
| ps2_dat_in | input | 1 | Sensed data line level |
| ps2_dat_drv | output | 1 | 1 pulls the data line low |

## Verification
The bench builds the block with HALF_CYC = 8 and HOLD_CYC = 20 instead of the microsecond-scale defaults. A whole frame then takes under two hundred cycles. The hold window and the abort paths can be hit with an exact cycle count, and pulse widths can be compared against 8 exactly. A behavioural host model shares the two wires through wired-AND logic. It can hold the clock, raise a send request, corrupt the parity or the stop bit, and cut a frame short, all in one short run.

// File: rtl/ps2d_pkg.sv
package ps2d_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_HI,
    ST_TX_LO,
    ST_RX_LO,
    ST_RX_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_REL
  } link_state_t;

  function automatic logic odd_par(input logic [DATA_BITS-1:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/ps2d_sync.sv
module ps2d_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ps2d_phase_timer.sv
module ps2d_phase_timer #(
  parameter int HALF_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(HALF_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (restart)      cnt_q <= CW'(HALF_CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ps2d_idle_watch.sv
module ps2d_idle_watch #(
  parameter int HOLD_CYC = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hi,
  output logic hold_ok
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !line_hi)            cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_ok = (cnt_q == CW'(HOLD_CYC));
endmodule

// File: rtl/ps2_dev_xcvr.sv
module ps2_dev_xcvr
  import ps2d_pkg::*;
#(
  parameter int HALF_CYC    = 5000,
  parameter int HOLD_CYC    = 6250,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err,
  output logic                 abort,
  input  logic                 ps2_clk_in,
  output logic                 ps2_clk_drv,
  input  logic                 ps2_dat_in,
  output logic                 ps2_dat_drv
);
  localparam int IDX_W    = $clog2(FRAME_BITS + 1);
  localparam int LAST_IDX = FRAME_BITS;
  localparam int STOP_IDX = DATA_BITS + 1;

  logic [1:0] line_s;
  logic       clk_s, dat_s;
  logic       hold_ok, expired, restart;

  link_state_t             st_q, st_nx;
  logic [IDX_W-1:0]        idx_q, idx_nx;
  logic [FRAME_BITS-1:0]   txsh_q, txsh_nx;
  logic [DATA_BITS:0]      rxsh_q, rxsh_nx;
  logic                    ferr_q, ferr_nx;
  logic                    abort_nx, done_nx;

  ps2d_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({ps2_dat_in, ps2_clk_in}),
    .d_out(line_s)
  );
  assign clk_s = line_s[0];
  assign dat_s = line_s[1];

  ps2d_idle_watch #(.HOLD_CYC(HOLD_CYC)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .line_hi(clk_s),
    .hold_ok(hold_ok)
  );

  ps2d_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .expired(expired)
  );

  assign tx_ready = (st_q == ST_IDLE) && hold_ok && clk_s && dat_s;
  assign restart  = (st_nx != st_q);

  always_comb begin
    st_nx    = st_q;
    idx_nx   = idx_q;
    txsh_nx  = txsh_q;
    rxsh_nx  = rxsh_q;
    ferr_nx  = ferr_q;
    abort_nx = 1'b0;
    done_nx  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (clk_s && !dat_s) begin
          st_nx   = ST_RX_LO;
          idx_nx  = '0;
          ferr_nx = 1'b0;
        end else if (tx_valid && tx_ready) begin
          st_nx   = ST_TX_HI;
          idx_nx  = '0;
          txsh_nx = {1'b1, odd_par(tx_data), tx_data, 1'b0};
        end
      end
      ST_TX_HI: if (expired) begin
        if (!clk_s) begin
          st_nx    = ST_IDLE;
          abort_nx = 1'b1;
        end else if (idx_q == IDX_W'(LAST_IDX)) begin
          st_nx = ST_IDLE;
        end else begin
          st_nx = ST_TX_LO;
        end
      end
      ST_TX_LO: if (expired) begin
        st_nx   = ST_TX_HI;
        idx_nx  = idx_q + 1'b1;
        txsh_nx = {1'b1, txsh_q[FRAME_BITS-1:1]};
      end
      ST_RX_LO: if (expired) st_nx = ST_RX_HI;
      ST_RX_HI: if (expired) begin
        if (!clk_s) begin
          st_nx    = ST_IDLE;
          abort_nx = 1'b1;
        end else if (idx_q == IDX_W'(STOP_IDX)) begin
          if (dat_s) begin
            st_nx = ST_ACK_LO;
          end else begin
            ferr_nx = 1'b1;
            st_nx   = ST_RX_LO;
          end
        end else begin
          rxsh_nx = {dat_s, rxsh_q[DATA_BITS:1]};
          idx_nx  = idx_q + 1'b1;
          st_nx   = ST_RX_LO;
        end
      end
      ST_ACK_LO: if (expired) st_nx = ST_ACK_HI;
      ST_ACK_HI: if (expired) begin
        st_nx   = ST_REL;
        done_nx = 1'b1;
      end
      ST_REL:  if (expired) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      idx_q         <= '0;
      txsh_q        <= '1;
      rxsh_q        <= '0;
      ferr_q        <= 1'b0;
      ps2_clk_drv   <= 1'b0;
      ps2_dat_drv   <= 1'b0;
      abort         <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      st_q        <= st_nx;
      idx_q       <= idx_nx;
      txsh_q      <= txsh_nx;
      rxsh_q      <= rxsh_nx;
      ferr_q      <= ferr_nx;
      ps2_clk_drv <= (st_q == ST_TX_LO) || (st_q == ST_RX_LO) || (st_q == ST_ACK_LO);
      ps2_dat_drv <= (((st_q == ST_TX_HI) || (st_q == ST_TX_LO)) && !txsh_q[0])
                     || (st_q == ST_ACK_LO) || (st_q == ST_ACK_HI);
      abort       <= abort_nx;
      rx_valid    <= done_nx;
      if (done_nx) begin
        rx_data       <= rxsh_q[DATA_BITS-1:0];
        rx_parity_err <= ~(^rxsh_q);
        rx_frame_err  <= ferr_q;
      end
    end
  end
endmodule

// File: rtl/ps2_dev_xcvr_chk.sv
module ps2_dev_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic abort,
  input logic ps2_clk_drv,
  input logic ps2_dat_drv
);
  // R8
  ack_held_at_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (ps2_dat_drv && !ps2_clk_drv));

  // R8
  ack_released_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (!ps2_dat_drv && !ps2_clk_drv));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!ps2_clk_drv && !ps2_dat_drv));

  // R3
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (!ps2_clk_drv && !ps2_dat_drv));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind ps2_dev_xcvr ps2_dev_xcvr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .abort      (abort),
  .ps2_clk_drv(ps2_clk_drv),
  .ps2_dat_drv(ps2_dat_drv)
);

// File: tb/ps2_dev_xcvr_bench.sv
module ps2_dev_xcvr_bench;
  localparam int HALF = 8;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       tx_valid = 1'b0;
  logic [7:0] tx_data  = 8'h00;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, rx_parity_err, rx_frame_err, abort;
  logic       dev_clk_drv, dev_dat_drv;
  logic       host_clk_drv = 1'b0;
  logic       host_dat_drv = 1'b0;
  wire        line_clk = ~(dev_clk_drv | host_clk_drv);
  wire        line_dat = ~(dev_dat_drv | host_dat_drv);

  ps2_dev_xcvr #(.HALF_CYC(HALF), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) u_ps2_dev_xcvr (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .abort(abort),
    .ps2_clk_in(line_clk), .ps2_clk_drv(dev_clk_drv),
    .ps2_dat_in(line_dat), .ps2_dat_drv(dev_dat_drv)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // port monitors, sampled on the falling system edge
  int         rx_cnt = 0;
  logic [7:0] rx_b = 8'h00;
  bit         rx_pe = 0, rx_fe = 0, rx_ackdrv = 0;
  int         abort_cnt = 0;
  int         pulse_cnt = 0;
  int         ack_pulses = 0;
  logic       prev_cd = 1'b0;
  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_b      = rx_data;
      rx_pe     = rx_parity_err;
      rx_fe     = rx_frame_err;
      rx_ackdrv = dev_dat_drv;
    end
    if (abort) abort_cnt++;
    if (dev_clk_drv && !prev_cd) begin
      pulse_cnt++;
      if (dev_dat_drv) ack_pulses++;
    end
    prev_cd = dev_clk_drv;
  end

  // host receiver: data read on each falling clock
  bit          cap_en = 0;
  int          cap_n  = 0;
  logic [10:0] cap_sh = '0;
  always @(posedge dev_clk_drv) begin
    if (cap_en) begin
      cap_sh = {line_dat, cap_sh[10:1]};
      cap_n++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] b, output int waited);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    waited   = 0;
    while (!tx_ready && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_frame();
    for (int i = 0; i < 2000 && cap_n < 11; i++) @(negedge clk);
    idle(2 * HALF + 4);
  endtask

  task automatic check_frame(input logic [7:0] b, input string tag);
    chk(cap_n == 11, {tag, " R1 bit count"}, cap_n, 11);
    chk(cap_sh[0] == 1'b0, {tag, " R1 start"}, cap_sh[0], 0);
    chk(cap_sh[8:1] == b, {tag, " R1 data"}, cap_sh[8:1], b);
    chk(cap_sh[9] == ~^b, {tag, " R1 parity"}, cap_sh[9], ~^b);
    chk(cap_sh[10] == 1'b1, {tag, " R1 stop"}, cap_sh[10], 1);
    chk(!dev_clk_drv && !dev_dat_drv, {tag, " R1 lines released"}, {dev_clk_drv, dev_dat_drv}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!dev_clk_drv && !dev_dat_drv, "R11 drives off", {dev_clk_drv, dev_dat_drv}, 0);
    chk(!rx_valid && !abort, "R11 pulses low", {rx_valid, abort}, 0);
    chk(!tx_ready, "R11 ready low before hold", tx_ready, 0);
    idle(HOLD + 6);
    chk(tx_ready, "R11 ready after hold", tx_ready, 1);
  endtask

  task automatic t_tx(input logic [7:0] b, input bit measure);
    int w, lo, hi;
    cap_n = 0; cap_en = 1;
    send_tx(b, w);
    if (measure) begin
      @(posedge dev_clk_drv);
      lo = 0;
      hi = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (dev_clk_drv) lo++; else break;
      end
      hi = 1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!dev_clk_drv) hi++; else break;
      end
      chk(lo == HALF, "R2 low width", lo, HALF);
      chk(hi == HALF, "R2 high gap", hi, HALF);
    end
    wait_frame();
    cap_en = 0;
    check_frame(b, "tx");
    idle(10);
  endtask

  task automatic t_tx_hold();
    int p, n;
    bit leaked;
    leaked = 0;
    cap_n = 0; cap_en = 1;
    @(negedge clk);
    host_clk_drv = 1'b1;
    idle(10);
    tx_valid = 1'b1;
    tx_data  = 8'h81;
    p = pulse_cnt;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_ready) leaked = 1;
    end
    chk(!leaked, "R3 no ready while clock held", leaked, 0);
    chk(pulse_cnt == p, "R3 no clocks while held", pulse_cnt - p, 0);
    host_clk_drv = 1'b0;
    n = 0;
    while (!tx_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n >= HOLD && n <= HOLD + 4, "R3 hold time before ready", n, HOLD);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_frame();
    cap_en = 0;
    check_frame(8'h81, "R3 held");
    idle(10);
  endtask

  task automatic t_tx_abort();
    int w, a0, p;
    bit rdy;
    rdy = 0;
    cap_en = 0;
    a0 = abort_cnt;
    send_tx(8'h3C, w);
    repeat (3) @(posedge dev_clk_drv);
    host_clk_drv = 1'b1;
    idle(4 * HALF);
    chk(abort_cnt == a0 + 1, "R4 abort pulse", abort_cnt - a0, 1);
    chk(!dev_clk_drv && !dev_dat_drv, "R4 lines released", {dev_clk_drv, dev_dat_drv}, 0);
    p = pulse_cnt;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_ready) rdy = 1;
    end
    chk(pulse_cnt == p, "R4 no further clocks", pulse_cnt - p, 0);
    chk(!rdy, "R4 not ready while inhibited", rdy, 0);
    host_clk_drv = 1'b0;
    idle(HOLD + 10);
    chk(pulse_cnt == p, "R4 byte dropped", pulse_cnt - p, 0);
  endtask

  task automatic host_send(input logic [7:0] b, input bit bad_par, input bit stop_low);
    int  r0, n;
    logic par;
    r0  = rx_cnt;
    par = (~^b) ^ bad_par;
    @(negedge clk);
    host_clk_drv = 1'b1;
    idle(10);
    host_dat_drv = 1'b1;
    idle(4);
    host_clk_drv = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(posedge dev_clk_drv);
      host_dat_drv = (i < 8) ? ~b[i] : ~par;
    end
    @(posedge dev_clk_drv);
    host_dat_drv = stop_low;
    if (stop_low) begin
      @(posedge dev_clk_drv);
      host_dat_drv = 1'b0;
    end
    n = 0;
    while (rx_cnt == r0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    idle(2);
  endtask

  task automatic t_rx(input logic [7:0] b, input bit bad_par, input bit stop_low, input string tag);
    int r0, a0;
    r0 = rx_cnt;
    a0 = ack_pulses;
    host_send(b, bad_par, stop_low);
    chk(rx_cnt == r0 + 1, {tag, " R5 one byte delivered"}, rx_cnt - r0, 1);
    chk(rx_b == b, {tag, " R5 byte value"}, rx_b, b);
    chk(rx_pe == bad_par, {tag, " R6 parity flag"}, rx_pe, bad_par);
    chk(rx_fe == stop_low, {tag, " R7 frame flag"}, rx_fe, stop_low);
    chk(ack_pulses - a0 == 1, {tag, " R8 one ack pulse"}, ack_pulses - a0, 1);
    chk(rx_ackdrv, {tag, " R8 data held at valid"}, rx_ackdrv, 1);
    idle(HALF + 2);
    chk(!dev_clk_drv && !dev_dat_drv, {tag, " R8 released"}, {dev_clk_drv, dev_dat_drv}, 0);
    idle(HOLD + 10);
  endtask

  task automatic t_rx_abort();
    int r0, a0;
    r0 = rx_cnt;
    a0 = abort_cnt;
    @(negedge clk);
    host_clk_drv = 1'b1;
    idle(10);
    host_dat_drv = 1'b1;
    idle(4);
    host_clk_drv = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge dev_clk_drv);
      host_dat_drv = ~i[0];
    end
    host_clk_drv = 1'b1;
    idle(4 * HALF);
    chk(abort_cnt == a0 + 1, "R9 abort pulse", abort_cnt - a0, 1);
    chk(rx_cnt == r0, "R9 no byte", rx_cnt - r0, 0);
    chk(!dev_clk_drv && !dev_dat_drv, "R9 lines released", {dev_clk_drv, dev_dat_drv}, 0);
    host_dat_drv = 1'b0;
    idle(6);
    host_clk_drv = 1'b0;
    idle(HOLD + 10);
    chk(rx_cnt == r0, "R9 still no byte", rx_cnt - r0, 0);
  endtask

  task automatic t_priority();
    int n;
    cap_en = 0;
    @(negedge clk);
    host_clk_drv = 1'b1;
    idle(5);
    tx_valid = 1'b1;
    tx_data  = 8'h5A;
    host_send(8'hC3, 0, 0);
    chk(rx_b == 8'hC3, "R10 host byte first", rx_b, 8'hC3);
    cap_n = 0; cap_en = 1;
    n = 0;
    while (!tx_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    tx_valid = 1'b0;
    wait_frame();
    cap_en = 0;
    check_frame(8'h5A, "R10 pending");
    idle(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    t_reset();
    t_tx(8'hA5, 1);
    t_tx(8'h00, 0);
    t_tx(8'h7F, 0);
    t_tx_hold();
    t_tx_abort();
    t_rx(8'h5C, 0, 0, "rx plain");
    t_rx(8'hFF, 0, 0, "rx ones");
    t_rx(8'h80, 1, 0, "rx badpar");
    t_rx(8'h1E, 0, 1, "rx badstop");
    t_rx_abort();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule